// File: doc/BRIEF.md
# RAW10 Byte Packer with Lane Striping

This block takes 10-bit raw Bayer pixels, one per cycle, through a valid/ready handshake. It packs each run of four pixels into five bytes. Four bytes hold the upper eight bits of each pixel. A fifth byte gathers the two low bits of all four pixels. The packed byte stream is then dealt out, in turn, across one, two or four output lanes. A beat carries one byte per active lane, with a strobe for the whole beat and an enable bit for each lane.

The lane count is chosen at run time and takes effect from the first pixel of each line. The sender marks the last pixel of a line, and the line length is a multiple of four pixels. After that last pixel the block flushes what is left. The final beat is padded with zero bytes, its enable bits show which lanes carry data, and a last-beat flag marks it. A small internal byte buffer takes up output stalls. The input ready signal drops before that buffer could overflow, so no pixel is lost under backpressure.

Top module: `raw10_lane_packer`

## Requirements
- R1: Four accepted pixels Q0..Q3 of a line produce exactly five bytes. The first four bytes are Q0[9:2], Q1[9:2], Q2[9:2] and Q3[9:2], in that order.
- R2: The fifth byte of each group is {Q3[1:0], Q2[1:0], Q1[1:0], Q0[1:0]}. Q0's low bits sit in bits 1:0 and Q3's in bits 7:6.
- R3: Byte k of a line's packed stream (k counted from 0) appears in beat floor(k/N) on lane k mod N. Lane j occupies laneData[8j+7:8j]. Every beat except the last of the line has all N enable bits set.
- R4: laneCfg selects the lane count N: 0 gives 1 lane, 1 gives 2 lanes, and 2 or 3 give 4 lanes.
- R5: With 4 lanes, the low-bit byte of the first group is lane 0 of beat 1, and the low-bit byte of the second group is lane 1 of beat 2.
- R6: laneCfg is sampled when the first pixel of a line is accepted. Changes to laneCfg later in that line have no effect on that line's beats.
- R7: The last beat of a line has laneLast=1. In that beat, laneByteEn bit j is 1 exactly for the lanes that carry a byte, and laneData is zero on every lane whose enable bit is 0. Lane enables are always contiguous from lane 0.
- R8: While laneValid=1 and laneReady=0, the beat on laneData and laneByteEn holds. pixReady is 1 only while the buffer holds no more than BUF_DEPTH-2 bytes. No pixel is lost or duplicated under any pattern of laneReady.
- R9: Once the last pixel of a line has been accepted, pixReady stays 0 until every byte of that line has left the block.
- R10: After reset, laneValid=0, laneByteEn=0, laneLast=0 and pixReady=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| laneCfg | input | 2 | Lane count select, sampled at line start |
| pixValid | input | 1 | Input pixel valid |
| pixData | input | 10 | Raw pixel value |
| pixLast | input | 1 | Marks the last pixel of a line |
| pixReady | output | 1 | Block can accept a pixel this cycle |
| laneValid | output | 1 | A beat is presented on the lanes |
| laneReady | input | 1 | Sink takes the presented beat |
| laneData | output | 32 | One byte per lane, lane j in bits 8j+7:8j |
| laneByteEn | output | 4 | Per-lane byte enable of the current beat |
| laneLast | output | 1 | Current beat is the last of the line |

## Verification
The two functions that collide are the arrival of a pixel, which appends one or two bytes at the tail of the buffer, and the departure of a beat, which shifts up to four bytes out of its head, both in the same clock edge. The bench provokes this with random laneReady, random gaps between pixels and random lane counts. It judges every beat against a byte-level model of the line built from the pixels sent. A stalled run fills the buffer until pixReady must fall, and a stalled end of line checks that the flush holds off the next line's first pixel.

// File: rtl/raw10_pkg.sv
package raw10_pkg;
  localparam int MAX_LANES = 4;
  localparam int POP_W = 3;

  // strobes from control to datapath for one clock
  typedef struct packed {
    logic             accept;   // a pixel is taken this cycle
    logic             pushTwo;  // pixel closes a group: high byte plus low-bit byte
    logic [1:0]       phase;    // position of the pixel inside its group
    logic [POP_W-1:0] popN;     // bytes leaving the head of the buffer
  } ctrlStrobeT;

  function automatic logic [2:0] lanesFromCfg(input logic [1:0] cfg);
    case (cfg)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/raw10_ctrl.sv
module raw10_ctrl
  import raw10_pkg::*;
#(
  parameter int BUF_DEPTH = 8,
  localparam int CNT_W = $clog2(BUF_DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [1:0]           laneCfg,
  input  logic                 pixValid,
  input  logic                 pixLast,
  input  logic                 laneReady,
  output logic                 pixReady,
  output logic                 laneValid,
  output logic                 laneLast,
  output logic [MAX_LANES-1:0] byteEn,
  output logic [CNT_W-1:0]     fill,
  output logic [CNT_W-1:0]     activeN,
  output logic                 lineStart,
  output ctrlStrobeT           ctl
);
  logic [1:0]       phase;
  logic [CNT_W-1:0] beatN;
  logic [1:0]       pushN;
  logic             drain;
  logic             accept;
  logic             pop;

  // the line is complete and its bytes are still leaving
  assign drain    = lineStart && (fill != '0);
  assign pixReady = (fill <= CNT_W'(BUF_DEPTH - 2)) && !drain;
  assign accept   = pixValid && pixReady;

  assign beatN     = (fill < activeN) ? fill : activeN;
  assign laneValid = (fill >= activeN) || drain;
  assign laneLast  = drain && (fill <= activeN);
  assign pop       = laneValid && laneReady;

  for (genvar j = 0; j < MAX_LANES; j++) begin : g_en
    assign byteEn[j] = laneValid && (CNT_W'(j) < beatN);
  end

  assign pushN = !accept ? 2'd0 : ((phase == 2'd3) ? 2'd2 : 2'd1);

  always_comb begin
    ctl         = '0;
    ctl.accept  = accept;
    ctl.pushTwo = accept && (phase == 2'd3);
    ctl.phase   = phase;
    ctl.popN    = pop ? POP_W'(beatN) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fill      <= '0;
      phase     <= '0;
      lineStart <= 1'b1;
      activeN   <= CNT_W'(1);
    end else begin
      fill <= fill - CNT_W'(ctl.popN) + CNT_W'(pushN);
      if (accept) begin
        phase     <= pixLast ? 2'd0 : phase + 2'd1;
        lineStart <= pixLast;
        if (lineStart) activeN <= CNT_W'(lanesFromCfg(laneCfg));
      end
    end
  end
endmodule

// File: rtl/raw10_datapath.sv
module raw10_datapath
  import raw10_pkg::*;
#(
  parameter int BUF_DEPTH = 8,
  localparam int CNT_W = $clog2(BUF_DEPTH + 1),
  localparam int IDX_W = $clog2(BUF_DEPTH)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrlStrobeT             ctl,
  input  logic [CNT_W-1:0]       fill,
  input  logic [9:0]             pixData,
  input  logic [MAX_LANES-1:0]   byteEn,
  output logic [MAX_LANES*8-1:0] laneData
);
  logic [7:0] bufMem [BUF_DEPTH];
  logic [7:0] nxtMem [BUF_DEPTH];
  logic [5:0] lowAcc;
  logic [7:0] hiByte;
  logic [7:0] loByte;

  assign hiByte = pixData[9:2];
  assign loByte = {pixData[1:0], lowAcc};

  // shift the head out by popN, then append new bytes after the survivors
  always_comb begin
    int keep;
    keep = int'(fill) - int'(ctl.popN);
    for (int i = 0; i < BUF_DEPTH; i++) begin
      int src;
      src = i + int'(ctl.popN);
      nxtMem[i] = 8'h00;
      if (src < int'(fill))
        nxtMem[i] = bufMem[IDX_W'(src)];
      else if (ctl.accept && (i == keep))
        nxtMem[i] = hiByte;
      else if (ctl.pushTwo && (i == keep + 1))
        nxtMem[i] = loByte;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < BUF_DEPTH; i++) bufMem[i] <= 8'h00;
      lowAcc <= '0;
    end else begin
      for (int i = 0; i < BUF_DEPTH; i++) bufMem[i] <= nxtMem[i];
      if (ctl.accept && !ctl.pushTwo) begin
        case (ctl.phase)
          2'd0:    lowAcc[1:0] <= pixData[1:0];
          2'd1:    lowAcc[3:2] <= pixData[1:0];
          default: lowAcc[5:4] <= pixData[1:0];
        endcase
      end
    end
  end

  for (genvar j = 0; j < MAX_LANES; j++) begin : g_lane
    assign laneData[8*j +: 8] = byteEn[j] ? bufMem[j] : 8'h00;
  end
endmodule

// File: rtl/raw10_lane_packer.sv
module raw10_lane_packer
  import raw10_pkg::*;
#(
  parameter int BUF_DEPTH = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [1:0]             laneCfg,
  input  logic                   pixValid,
  input  logic [9:0]             pixData,
  input  logic                   pixLast,
  output logic                   pixReady,
  output logic                   laneValid,
  input  logic                   laneReady,
  output logic [MAX_LANES*8-1:0] laneData,
  output logic [MAX_LANES-1:0]   laneByteEn,
  output logic                   laneLast
);
  localparam int CNT_W = $clog2(BUF_DEPTH + 1);

  ctrlStrobeT       ctl;
  logic [CNT_W-1:0] fill;
  logic [CNT_W-1:0] activeN;
  logic             lineStart;

  raw10_ctrl #(.BUF_DEPTH(BUF_DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .laneCfg(laneCfg), .pixValid(pixValid),
    .pixLast(pixLast), .laneReady(laneReady), .pixReady(pixReady),
    .laneValid(laneValid), .laneLast(laneLast), .byteEn(laneByteEn),
    .fill(fill), .activeN(activeN), .lineStart(lineStart), .ctl(ctl)
  );

  raw10_datapath #(.BUF_DEPTH(BUF_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .fill(fill), .pixData(pixData),
    .byteEn(laneByteEn), .laneData(laneData)
  );
endmodule

// File: rtl/raw10_lane_packer_chk.sv
module raw10_lane_packer_chk #(
  parameter int BUF_DEPTH = 8,
  localparam int CNT_W = $clog2(BUF_DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             pixReady,
  input logic             laneValid,
  input logic             laneReady,
  input logic [31:0]      laneData,
  input logic [3:0]       laneByteEn,
  input logic             laneLast,
  input logic [CNT_W-1:0] fill,
  input logic [CNT_W-1:0] activeN,
  input logic             lineStart
);
  logic [3:0] fullMask;
  always_comb begin
    if (activeN >= CNT_W'(4))      fullMask = 4'hF;
    else if (activeN == CNT_W'(2)) fullMask = 4'h3;
    else                           fullMask = 4'h1;
  end

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rstN)
    fill <= CNT_W'(BUF_DEPTH));

  p_hold_stalled_r8: assert property (@(posedge clk) disable iff (!rstN)
    (laneValid && !laneReady) |=> (laneValid && $stable(laneData) && $stable(laneByteEn)));

  p_full_midline_r3: assert property (@(posedge clk) disable iff (!rstN)
    (laneValid && !laneLast) |-> (laneByteEn == fullMask));

  p_contig_en_r7: assert property (@(posedge clk) disable iff (!rstN)
    laneValid |-> (laneByteEn[0] && ((laneByteEn & (laneByteEn + 4'd1)) == 4'd0)));

  p_lanes_frozen_r6: assert property (@(posedge clk) disable iff (!rstN)
    !lineStart |=> $stable(activeN));

  p_flush_blocks_r9: assert property (@(posedge clk) disable iff (!rstN)
    (laneValid && laneLast && !laneReady) |-> !pixReady);
endmodule

bind raw10_lane_packer raw10_lane_packer_chk #(.BUF_DEPTH(BUF_DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .pixReady(pixReady), .laneValid(laneValid),
  .laneReady(laneReady), .laneData(laneData), .laneByteEn(laneByteEn),
  .laneLast(laneLast), .fill(fill), .activeN(activeN), .lineStart(lineStart)
);

// File: tb/tb_raw10_lane_packer.sv
module tb_raw10_lane_packer;
  localparam int BUF_DEPTH = 8;

  logic        clk = 1'b0;
  logic        rstN;
  logic [1:0]  laneCfg;
  logic        pixValid;
  logic [9:0]  pixData;
  logic        pixLast;
  logic        pixReady;
  logic        laneValid;
  logic        laneReady = 1'b0;
  logic [31:0] laneData;
  logic [3:0]  laneByteEn;
  logic        laneLast;

  raw10_lane_packer #(.BUF_DEPTH(BUF_DEPTH)) dut (.*);

  always #4 clk = ~clk;  // 125 MHz

  int nChecks = 0;
  int nFails = 0;
  bit stallOut = 1'b0;
  bit done = 1'b0;
  logic [9:0]  px [64];
  logic [36:0] expQ [$];
  logic [36:0] gotQ [$];

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int lanesOf(input logic [1:0] cfg);
    return (cfg == 2'd0) ? 1 : ((cfg == 2'd1) ? 2 : 4);
  endfunction

  // byte-level model of one line: packing then striping
  task automatic modelLine(input int n, input logic [1:0] cfg);
    logic [7:0] q [$];
    int nl;
    nl = lanesOf(cfg);
    for (int g = 0; g < n / 4; g++) begin
      for (int i = 0; i < 4; i++) q.push_back(px[4*g+i][9:2]);
      q.push_back({px[4*g+3][1:0], px[4*g+2][1:0], px[4*g+1][1:0], px[4*g][1:0]});
    end
    for (int s = 0; s < q.size(); s += nl) begin
      logic [31:0] d;
      logic [3:0]  e;
      d = '0;
      e = '0;
      for (int j = 0; j < nl; j++)
        if (s + j < q.size()) begin
          d[8*j +: 8] = q[s+j];
          e[j] = 1'b1;
        end
      expQ.push_back({(s + nl >= q.size()), e, d});
    end
  endtask

  task automatic sendPix(input logic [9:0] d, input bit last, input bit randCfg, input int maxGap);
    @(negedge clk);
    pixValid = 1'b1;
    pixData  = d;
    pixLast  = last;
    while (!pixReady) @(negedge clk);
    @(posedge clk);
    #1;
    pixValid = 1'b0;
    pixLast  = 1'b0;
    if (randCfg) laneCfg = 2'($urandom % 4);
    repeat ($urandom % (maxGap + 1)) @(posedge clk);
  endtask

  task automatic sendLine(input int n, input logic [1:0] cfg, input bit randCfg, input int maxGap);
    laneCfg = cfg;
    modelLine(n, cfg);
    for (int k = 0; k < n; k++) sendPix(px[k], k == n - 1, randCfg, maxGap);
  endtask

  task automatic waitDrain();
    int t;
    t = 0;
    while (expQ.size() != 0 && t < 3000) begin
      @(negedge clk);
      t++;
    end
    repeat (3) @(negedge clk);
  endtask

  // sink: random readiness, driven just after the active edge
  always @(posedge clk) begin
    #1;
    laneReady = stallOut ? 1'b0 : (($urandom % 10) < 7);
  end

  // monitor: every beat taken is compared with the model (R1 R2 R3 R4 R7)
  always @(negedge clk) begin
    if (rstN && laneValid && laneReady) begin
      logic [36:0] got;
      got = {laneLast, laneByteEn, laneData};
      gotQ.push_back(got);
      if (expQ.size() == 0) begin
        check(1'b0, "R8 beat without pending bytes", 64'(got), 64'(0));
      end else begin
        check(got == expQ[0], "R1 R2 R3 R4 R7 beat content", 64'(got), 64'(expQ[0]));
        void'(expQ.pop_front());
      end
    end
  end

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL R8 watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int acc;
    int expAcc;
    int bytes;
    logic [31:0] held;
    void'($urandom(32'h1a2b3c));
    rstN = 1'b0;
    laneCfg = 2'd0;
    pixValid = 1'b0;
    pixData = '0;
    pixLast = 1'b0;
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check(laneValid == 1'b0, "R10 laneValid after reset", 64'(laneValid), 64'(0));
    check(laneByteEn == 4'h0, "R10 laneByteEn after reset", 64'(laneByteEn), 64'(0));
    check(laneLast == 1'b0, "R10 laneLast after reset", 64'(laneLast), 64'(0));
    check(pixReady == 1'b1, "R10 pixReady after reset", 64'(pixReady), 64'(1));

    // R5: four lanes, low-bit byte placement; 15 bytes give a 3-byte last beat
    gotQ.delete();
    for (int k = 0; k < 12; k++) px[k] = 10'($urandom);
    px[0][1:0] = 2'd1; px[1][1:0] = 2'd2; px[2][1:0] = 2'd3; px[3][1:0] = 2'd0;
    px[4][1:0] = 2'd3; px[5][1:0] = 2'd3; px[6][1:0] = 2'd0; px[7][1:0] = 2'd1;
    sendLine(12, 2'd2, 1'b0, 1);
    waitDrain();
    check(gotQ.size() == 4, "R5 beat count", 64'(gotQ.size()), 64'(4));
    if (gotQ.size() == 4) begin
      check(gotQ[1][7:0] == 8'h39, "R5 R2 first low byte on lane 0 beat 1", 64'(gotQ[1][7:0]), 64'h39);
      check(gotQ[2][15:8] == 8'h4F, "R5 R2 second low byte on lane 1 beat 2", 64'(gotQ[2][15:8]), 64'h4F);
      check(gotQ[3][35:32] == 4'b0111, "R7 partial enables", 64'(gotQ[3][35:32]), 64'h7);
      check(gotQ[3][31:24] == 8'h00, "R7 padding zero", 64'(gotQ[3][31:24]), 64'h0);
      check(gotQ[3][36] == 1'b1, "R7 last flag", 64'(gotQ[3][36]), 64'h1);
    end

    // R6: one lane chosen, laneCfg changed right after the first pixel
    gotQ.delete();
    for (int k = 0; k < 16; k++) px[k] = 10'($urandom);
    laneCfg = 2'd0;
    modelLine(16, 2'd0);
    sendPix(px[0], 1'b0, 1'b0, 0);
    laneCfg = 2'd2;
    for (int k = 1; k < 16; k++) sendPix(px[k], k == 15, 1'b0, 0);
    waitDrain();
    check(gotQ.size() == 20, "R6 single-lane beats despite mid-line change", 64'(gotQ.size()), 64'(20));

    // R8: output stalled, buffer fills until pixReady falls
    waitDrain();
    stallOut = 1'b1;
    repeat (2) @(posedge clk);
    for (int k = 0; k < 8; k++) px[k] = 10'($urandom);
    laneCfg = 2'd2;
    modelLine(8, 2'd2);
    expAcc = 0;
    bytes = 0;
    for (int k = 0; k < 8; k++) begin
      if (bytes > BUF_DEPTH - 2) break;
      bytes += (k % 4 == 3) ? 2 : 1;
      expAcc++;
    end
    acc = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (!pixReady) break;
      pixValid = 1'b1;
      pixData = px[k];
      pixLast = (k == 7);
      @(posedge clk);
      #1;
      pixValid = 1'b0;
      pixLast = 1'b0;
      acc++;
    end
    check(acc == expAcc, "R8 pixels taken while stalled", 64'(acc), 64'(expAcc));
    @(negedge clk);
    check(pixReady == 1'b0, "R8 pixReady low when buffer full", 64'(pixReady), 64'(0));
    held = laneData;
    repeat (3) @(negedge clk);
    check(laneValid && laneData == held, "R8 beat held under stall", 64'(laneData), 64'(held));
    stallOut = 1'b0;
    for (int k = acc; k < 8; k++) sendPix(px[k], k == 7, 1'b0, 0);
    waitDrain();

    // R9: stalled end of line holds off the next line
    stallOut = 1'b1;
    repeat (2) @(posedge clk);
    for (int k = 0; k < 4; k++) px[k] = 10'($urandom);
    laneCfg = 2'd3;
    modelLine(4, 2'd3);
    for (int k = 0; k < 4; k++) sendPix(px[k], k == 3, 1'b0, 0);
    @(negedge clk);
    check(pixReady == 1'b0, "R9 next line held while flushing", 64'(pixReady), 64'(0));
    check(laneValid && !laneLast && laneByteEn == 4'hF, "R7 first of two flush beats full",
          64'({laneValid, laneLast, laneByteEn}), 64'({1'b1, 1'b0, 4'hF}));
    stallOut = 1'b0;
    waitDrain();

    // random lines, lane count reshuffled after every pixel (R6)
    for (int ln = 0; ln < 40; ln++) begin
      int n;
      n = 4 * (1 + int'($urandom % 10));
      for (int k = 0; k < n; k++) px[k] = 10'($urandom);
      sendLine(n, 2'($urandom % 4), 1'b1, 2);
    end
    waitDrain();
    check(expQ.size() == 0, "R8 every modelled beat delivered", 64'(expQ.size()), 64'(0));

    done = 1'b1;
    summary();
    $finish;
  end
endmodule